// File: doc/BRIEF.md
# Programmable 16-bit Reload Interval Timer

This block is a 16-bit down-counting interval timer that runs from a divided copy of the system clock. A byte-wide register port programs it. Software sets a count enable, a one-shot or continuous mode, an interrupt gate, an output pin enable and polarity, a prescaler select, and a 16-bit start value written as two bytes. The counter does not move after enable alone. A start event is needed, either a software trigger bit or a rising edge on an external trigger input. The start event copies the start value into the counter.

Each time the counter wraps from 0x0000 to 0xFFFF, it sets a sticky flag and flips a toggle output. In continuous mode it then reloads and keeps counting. In one-shot mode it stops at 0xFFFF and waits for a new start. The interrupt request is the sticky flag gated by the interrupt enable.

Register map (byte address on `wr_addr`/`rd_addr`):
- 0: control. bit0 count enable, bit1 start trigger (write only, reads 0), bit2 wrap flag, bit3 interrupt enable, bit4 continuous mode, bit5 output polarity, bit6 output enable. Bit7 reads 0.
- 1: prescaler select, bits 2:0.
- 2: start value bits 15:8.
- 3: start value bits 7:0.
- 4: live counter bits 15:8 (read only).
- 5: live counter bits 7:0 (read only).

Top module: `interval_timer16`

## Requirements
- R1: After reset, every register, the counter, the toggle level and the wrap flag are 0, so `irq` and `tmr_out` are 0.
- R2: Prescaler select k in 0..6 gives one count tick every 2^k clocks, taken from a free-running prescaler that starts at 0 when reset is released. Select 7 gives no ticks, so the counter holds its value.
- R3: A start event loads the start value into the counter and begins counting on the next tick. A start event is either a write to address 0 with bit0=1 and bit1=1, or a rising edge on `ext_trig` while the count enable is 1. If the same write sets the enable and the trigger together, counting starts in that cycle.
- R4: With the count enable at 0, the trigger bit and `ext_trig` edges have no effect. Clearing the enable stops the counter at its current value.
- R5: While running, each tick lowers the counter by 1. A tick at 0x0000 is a wrap. In continuous mode (bit4=1) a wrap reloads the start value, so a start value N gives one wrap every N+1 ticks.
- R6: In one-shot mode (bit4=0), a wrap leaves the counter at 0xFFFF and stops it until the next start event.
- R7: A wrap sets the flag (address 0, bit2). Writing 0 to that bit clears the flag and writing 1 leaves it unchanged. If a wrap and a clearing write happen in the same cycle, the flag ends up set.
- R8: `irq` is 1 exactly when the wrap flag and the interrupt enable are both 1.
- R9: The toggle level inverts on every wrap and returns to 0 on every start event. `tmr_out` equals the toggle level XOR the polarity bit when the output enable is 1, and is 0 otherwise.
- R10: Reading addresses 0 to 5 returns the register map above, with the trigger bit always reading 0. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write byte address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read byte address |
| rd_data | output | 8 | Read data (combinational) |
| ext_trig | input | 1 | External start input, rising edge acts |
| irq | output | 1 | Interrupt request |
| tmr_out | output | 1 | Toggle output pin |

## Verification
Two things can fall in the same cycle: a wrap setting the flag and a control write clearing it. The bench provokes this by rewriting the control byte with the flag bit at 0 on every cycle while the counter wraps every third tick. Some of those writes therefore land exactly on a wrap. A behavioural reference model holds the expected flag and `irq` each cycle, and the bench compares against it, so a design where the clear wins shows up at the colliding edge. The bench also compares a trigger landing on the wrap cycle, where the reload from the start event must win over the wrap.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   localparam int DATA_W  = 8;
   localparam int ADDR_W  = 3;
   localparam int CNT_W   = 2 * DATA_W;
   localparam int SEL_W   = 3;

   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] A_CSEL  = 3'd1;
   localparam logic [ADDR_W-1:0] A_RLD_H = 3'd2;
   localparam logic [ADDR_W-1:0] A_RLD_L = 3'd3;
   localparam logic [ADDR_W-1:0] A_CNT_H = 3'd4;
   localparam logic [ADDR_W-1:0] A_CNT_L = 3'd5;

   localparam int B_EN   = 0;
   localparam int B_TRG  = 1;
   localparam int B_FLAG = 2;
   localparam int B_IEN  = 3;
   localparam int B_CONT = 4;
   localparam int B_POL  = 5;
   localparam int B_OEN  = 6;

   typedef struct packed {
      logic       oen;
      logic       pol;
      logic       cont;
      logic       ien;
      logic       en;
      logic [SEL_W-1:0] csel;
   } tmr_cfg_t;
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
   parameter int STAGES = 6,
   parameter int SEL_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] csel,
   output logic             tick
);
   localparam int NSEL = 1 << SEL_W;

   generate
      if (STAGES < 1 || STAGES >= NSEL) begin : g_bad_stages
         $error("tmr_prescale: STAGES must lie in 1..2**SEL_W-1");
      end
   endgenerate

   logic [STAGES-1:0] pre;
   logic [STAGES:0]   tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre <= '0;
      else        pre <= pre + 1'b1;
   end

   assign tap[0] = 1'b1;
   generate
      for (genvar k = 1; k <= STAGES; k++) begin : g_tap
         assign tap[k] = &pre[k-1:0];
      end
   endgenerate

   always_comb begin
      tick = 1'b0;
      for (int k = 0; k <= STAGES; k++)
         if (csel == SEL_W'(k)) tick = tap[k];
   end

   // R2: an unused select must never produce a tick
   always_comb begin
      if (rst_n && csel > SEL_W'(STAGES))
         a_r2_no_tick_unused: assert (!tick);
   end
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start,
   input  logic             halt,
   input  logic             cont,
   input  logic [CNT_W-1:0] reload,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] count,
   output logic             flag,
   output logic             tog
);
   logic run;
   logic wrap;

   assign wrap = run & tick & ~start & ~halt & (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         run   <= 1'b0;
         flag  <= 1'b0;
         tog   <= 1'b0;
      end else begin
         flag <= (flag & ~flag_clr) | wrap;
         if (start) begin
            count <= reload;
            run   <= 1'b1;
            tog   <= 1'b0;
         end else if (halt) begin
            run <= 1'b0;
         end else if (run && tick) begin
            if (count == '0) begin
               tog <= ~tog;
               if (cont) count <= reload;
               else begin
                  count <= '1;
                  run   <= 1'b0;
               end
            end else begin
               count <= count - 1'b1;
            end
         end
      end
   end

   a_r3_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (run && count == $past(reload) && !tog));
   a_r6_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !cont) |=> (!run && count == {CNT_W{1'b1}}));
   a_r5_cont_reloads: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && cont) |=> (run && count == $past(reload)));
   a_r7_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> flag);
   a_r9_wrap_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (tog != $past(tog)));
   a_r4_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !start) |=> $stable(count));
endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
   import tmr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              ext_trig,
   input  logic [CNT_W-1:0]  count,
   input  logic              flag,
   output logic [DATA_W-1:0] rd_data,
   output tmr_cfg_t          cfg,
   output logic [CNT_W-1:0]  reload,
   output logic              start,
   output logic              halt,
   output logic              flag_clr
);
   logic ext_q;
   logic wr_ctrl;
   logic en_now;

   assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
   assign en_now   = wr_ctrl ? wr_data[B_EN] : cfg.en;
   assign start    = (wr_ctrl && wr_data[B_EN] && wr_data[B_TRG]) ||
                     (ext_trig && !ext_q && en_now);
   assign halt     = !en_now;
   assign flag_clr = wr_ctrl && !wr_data[B_FLAG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg    <= '0;
         reload <= '0;
         ext_q  <= 1'b0;
      end else begin
         ext_q <= ext_trig;
         if (wr_ctrl) begin
            cfg.en   <= wr_data[B_EN];
            cfg.ien  <= wr_data[B_IEN];
            cfg.cont <= wr_data[B_CONT];
            cfg.pol  <= wr_data[B_POL];
            cfg.oen  <= wr_data[B_OEN];
         end
         if (wr_en && wr_addr == A_CSEL)  cfg.csel <= wr_data[SEL_W-1:0];
         if (wr_en && wr_addr == A_RLD_H) reload[CNT_W-1:DATA_W] <= wr_data;
         if (wr_en && wr_addr == A_RLD_L) reload[DATA_W-1:0] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CTRL: begin
            rd_data[B_EN]   = cfg.en;
            rd_data[B_FLAG] = flag;
            rd_data[B_IEN]  = cfg.ien;
            rd_data[B_CONT] = cfg.cont;
            rd_data[B_POL]  = cfg.pol;
            rd_data[B_OEN]  = cfg.oen;
         end
         A_CSEL:  rd_data[SEL_W-1:0] = cfg.csel;
         A_RLD_H: rd_data = reload[CNT_W-1:DATA_W];
         A_RLD_L: rd_data = reload[DATA_W-1:0];
         A_CNT_H: rd_data = count[CNT_W-1:DATA_W];
         A_CNT_L: rd_data = count[DATA_W-1:0];
         default: rd_data = '0;
      endcase
   end

   a_r4_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg.en && !wr_ctrl) |-> !start);
   a_r10_trg_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == A_CTRL) |-> !rd_data[B_TRG]);
endmodule

// File: rtl/interval_timer16.sv
`timescale 1ns/1ps
module interval_timer16
   import tmr_pkg::*;
#(
   parameter int PRE_STAGES = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ext_trig,
   output logic              irq,
   output logic              tmr_out
);
   tmr_cfg_t         cfg;
   logic [CNT_W-1:0] reload;
   logic [CNT_W-1:0] count;
   logic             start, halt, flag_clr, flag, tog, tick;

   tmr_regs u_regs (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .ext_trig,
      .count, .flag, .rd_data, .cfg, .reload, .start, .halt, .flag_clr
   );

   tmr_prescale #(.STAGES(PRE_STAGES), .SEL_W(SEL_W)) u_pre (
      .clk, .rst_n, .csel(cfg.csel), .tick
   );

   tmr_core #(.CNT_W(CNT_W)) u_core (
      .clk, .rst_n, .tick, .start, .halt, .cont(cfg.cont), .reload,
      .flag_clr, .count, .flag, .tog
   );

   assign irq     = flag & cfg.ien;
   assign tmr_out = cfg.oen & (tog ^ cfg.pol);

   a_r8_irq_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> !irq);
   a_r9_out_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.oen |-> !tmr_out);
endmodule

// File: tb/interval_timer16_tb.sv
`timescale 1ns/1ps
module interval_timer16_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic       ext_trig = 1'b0;
   logic [7:0] rd_data;
   logic       irq, tmr_out;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   interval_timer16 u_dut (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
      .ext_trig, .irq, .tmr_out
   );

   // behavioural reference state
   int m_pre, m_cnt, m_rel, m_csel;
   bit m_run, m_flag, m_tog, m_en, m_ien, m_cont, m_pol, m_oen, m_extp;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pre = 0; m_cnt = 0; m_rel = 0; m_csel = 0;
         m_run = 0; m_flag = 0; m_tog = 0; m_en = 0; m_ien = 0;
         m_cont = 0; m_pol = 0; m_oen = 0; m_extp = 0;
      end else begin
         int div;
         bit tk, w0, en_now, go, clr, wrapped;
         div = 1 << m_csel;
         tk = (m_csel != 7) && ((m_pre % div) == div - 1);
         w0 = wr_en && wr_addr == 0;
         en_now = w0 ? wr_data[0] : m_en;
         go = (w0 && wr_data[0] && wr_data[1]) || (ext_trig && !m_extp && en_now);
         clr = w0 && !wr_data[2];
         wrapped = 0;
         if (go) begin m_cnt = m_rel; m_run = 1; m_tog = 0; end
         else if (!en_now) m_run = 0;
         else if (m_run && tk) begin
            if (m_cnt == 0) begin
               wrapped = 1; m_tog = !m_tog;
               if (m_cont) m_cnt = m_rel; else begin m_cnt = 65535; m_run = 0; end
            end else m_cnt = m_cnt - 1;
         end
         m_flag = (m_flag && !clr) || wrapped;
         if (w0) begin
            m_en = wr_data[0]; m_ien = wr_data[3]; m_cont = wr_data[4];
            m_pol = wr_data[5]; m_oen = wr_data[6];
         end
         if (wr_en && wr_addr == 1) m_csel = wr_data[2:0];
         if (wr_en && wr_addr == 2) m_rel = (m_rel & 255) | (wr_data << 8);
         if (wr_en && wr_addr == 3) m_rel = (m_rel & 65280) | wr_data;
         m_pre = (m_pre + 1) % 64;
         m_extp = ext_trig;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare every clock, shortly after the edge
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         int exp_rd;
         string tg;
         case (rd_addr)
            3'd0: begin exp_rd = {1'b0, m_oen, m_pol, m_cont, m_ien, m_flag, 1'b0, m_en}; tg = "R7/R10 ctrl"; end
            3'd1: begin exp_rd = m_csel; tg = "R10 csel"; end
            3'd2: begin exp_rd = m_rel >> 8; tg = "R10 rld_h"; end
            3'd3: begin exp_rd = m_rel & 255; tg = "R10 rld_l"; end
            3'd4: begin exp_rd = m_cnt >> 8; tg = "R5/R6 cnt_h"; end
            3'd5: begin exp_rd = m_cnt & 255; tg = "R2/R5 cnt_l"; end
            default: begin exp_rd = 0; tg = "R10 unmapped"; end
         endcase
         check(tg, rd_data, exp_rd);
         check("R8 irq", irq, m_flag && m_ien);
         check("R9 tmr_out", tmr_out, m_oen && (m_tog ^ m_pol));
      end
   end

   task automatic step();
      @(negedge clk);
      wr_en = 0;
      rd_addr = (rd_addr >= 3'd6) ? 3'd0 : rd_addr + 3'd1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      rd_addr = (rd_addr >= 3'd6) ? 3'd0 : rd_addr + 3'd1;
      wr_en = 1; wr_addr = a; wr_data = d;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1; n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #12;
      check("R1 reset irq", irq, 0);
      check("R1 reset out", tmr_out, 0);
      check("R1 reset ctrl", rd_data, 0);
      @(negedge clk); rst_n = 1;
      // R10 readback sweep incl. unmapped address 6
      idle(8);
      // R3 same-write start, continuous mode, divide by 1
      wr(3'd2, 8'h00); wr(3'd3, 8'h03); wr(3'd1, 8'h00);
      wr(3'd0, 8'h5B);
      idle(20);
      // R7 clear with 0, keep with 1
      wr(3'd0, 8'h5D); idle(2);
      wr(3'd0, 8'h59); idle(3);
      // R7 collision: clear on every cycle while wrapping every 3 ticks
      wr(3'd3, 8'h02);
      for (int i = 0; i < 14; i++) wr(3'd0, 8'h59);
      idle(2);
      // R3 trigger near a wrap, reload wins
      for (int i = 0; i < 6; i++) begin wr(3'd0, 8'h5B); idle(i % 3); end
      // R6 one-shot, divide by 4, inverted polarity
      wr(3'd1, 8'h02); wr(3'd0, 8'h6B); idle(30);
      // R3 external start while enabled
      ext_trig = 1; idle(3); ext_trig = 0; idle(25);
      // R2 select 7 freezes counter; then divide by 64
      wr(3'd0, 8'h53); wr(3'd1, 8'h07); idle(20);
      wr(3'd1, 8'h06); idle(200);
      // R4 disable halts; trigger and ext edge ignored while disabled
      wr(3'd1, 8'h00); wr(3'd0, 8'h53); idle(2);
      wr(3'd0, 8'h50); idle(5);
      wr(3'd0, 8'h52); idle(5);
      ext_trig = 1; idle(2); ext_trig = 0; idle(5);
      // R4 enable without trigger does not start; R3 ext starts
      wr(3'd0, 8'h51); idle(6);
      ext_trig = 1; idle(1); ext_trig = 0; idle(12);
      // R9 output disabled
      wr(3'd0, 8'h31); idle(10);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule